// File: doc/BRIEF.md
# Pipeline Exception Flush Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Fetch, decode, execute and memory can report a fault in a given cycle. Each stage has its own fixed set of fault kinds. Write-back never faults. When one or more stages report a fault, the controller picks the oldest faulting instruction, which is the one furthest down the pipeline. It then starts a precise shutdown at the next clock edge.

At that edge the controller asserts a flush for the faulting stage and for every younger stage, so that their pipeline latches are loaded with zeros. Older stages are left alone and drain normally. In the same cycle it asks fetch to inject a trap instruction. It also records the following:
- the faulting PC;
- a 3-bit cause;
- whether the faulting instruction occupied a branch delay slot.

For a delay-slot fault it also keeps the PC of the owning branch and that branch's target, so the handler has everything it needs to restart correctly.

An older instruction can fault after a younger one has already trapped. In that case the new, older fault simply takes over: it flushes again and overwrites the saved state. This keeps exceptions precise.

Top module: `exc_flush_ctrl`

## Requirements
- R1: After synchronous reset, flush, trap request, saved PC, cause, delay-slot flag, saved branch PC and saved target are all zero.
- R2: A fault reported in the cycle before clock edge N makes the trap request high for exactly the cycle after edge N. The flush outputs change at that same edge.
- R3: When stage k (0 fetch, 1 decode, 2 execute, 3 memory) is selected, flush bits 0..k are 1 and all higher flush bits are 0.
- R4: When several stages fault together, the highest-numbered faulting stage is selected.
- R5: The cause is encoded as 0 fetch page fault, 1 fetch misaligned, 2 fetch protection, 3 undefined opcode, 4 arithmetic, 5 data page fault, 6 data misaligned, 7 data protection. Within the fetch or memory 3-bit fault input, bit 0 is page fault, bit 1 is misaligned and bit 2 is protection, and the lowest set bit wins.
- R6: The saved PC equals the PC of the selected stage.
- R7: If the selected stage's delay-slot input is 1, the delay-slot flag is set, the saved branch PC equals the PC of stage k+1, and the saved target equals the selected stage's target input. Otherwise all three are cleared to 0.
- R8: In a cycle with no fault, the next cycle has trap request 0 and all flush bits 0, and the saved PC, cause and delay-slot fields keep their values.
- R9: Write-back (flush bit 4) is never flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_exc | input | 3 | Fetch faults: bit0 page, bit1 misaligned, bit2 protection |
| id_exc | input | 1 | Decode undefined opcode |
| ex_exc | input | 1 | Execute arithmetic fault |
| mem_exc | input | 3 | Memory faults: bit0 page, bit1 misaligned, bit2 protection |
| stage_pc | input | 5*PCW | PC per stage, stage s at bits [s*PCW +: PCW] |
| stage_dslot | input | 4 | Delay-slot marker for stages 0..3 |
| stage_tgt | input | 4*PCW | Owning branch target for stages 0..3 |
| flush | output | 5 | Zero the latch of stage s |
| trap_fetch | output | 1 | Inject trap instruction at fetch |
| epc | output | PCW | Saved faulting PC |
| cause | output | 3 | Saved cause code |
| epc_in_dslot | output | 1 | Faulting instruction was in a delay slot |
| epc_branch_pc | output | PCW | Saved PC of the owning branch |
| epc_branch_tgt | output | PCW | Saved target of the owning branch |

## Verification
The assertions check on every cycle the properties that hold regardless of data:
- the trap and flush outputs appear together;
- the flush pattern is a contiguous run starting at fetch;
- write-back is never flushed;
- a memory fault always wins;
- a quiet cycle leaves the saved state unchanged.

The exact cause chosen inside a stage's fault bits, the saved PC, and the delay-slot branch PC and target are data-dependent. These are shown only by the bench's sweep. That sweep covers every combination of the eight fault inputs, with varying PCs and delay-slot markers, and each fault cycle is followed by an idle cycle.

// File: rtl/exc_flush_pkg.sv
package exc_flush_pkg;
  localparam int NSTAGE = 5;
  localparam int NFAULT = 4;
  localparam int SELW   = $clog2(NFAULT);

  typedef enum logic [2:0] {
    C_IF_PAGE   = 3'd0,
    C_IF_ALIGN  = 3'd1,
    C_IF_PROT   = 3'd2,
    C_UNDEF     = 3'd3,
    C_ARITH     = 3'd4,
    C_MEM_PAGE  = 3'd5,
    C_MEM_ALIGN = 3'd6,
    C_MEM_PROT  = 3'd7
  } exc_cause_t;

  // lowest set bit of a 3-bit fault group
  function automatic logic [1:0] low_bit3(input logic [2:0] v);
    if (v[0])      return 2'd0;
    else if (v[1]) return 2'd1;
    else           return 2'd2;
  endfunction
endpackage

// File: rtl/exc_select.sv
module exc_select
  import exc_flush_pkg::*;
(
  input  logic [2:0]        if_exc,
  input  logic [2:0]        mem_exc,
  input  logic [NFAULT-1:0] any_fault,
  output logic              hit,
  output logic [SELW-1:0]   sel,
  output exc_cause_t        cause_nx
);
  always_comb begin
    sel = '0;
    for (int i = 0; i < NFAULT; i++)
      if (any_fault[i]) sel = SELW'(i);
  end

  assign hit = |any_fault;

  always_comb begin
    case (sel)
      2'd0:    cause_nx = exc_cause_t'({1'b0, low_bit3(if_exc)});
      2'd1:    cause_nx = C_UNDEF;
      2'd2:    cause_nx = C_ARITH;
      default: cause_nx = exc_cause_t'(3'd5 + {1'b0, low_bit3(mem_exc)});
    endcase
  end
endmodule

// File: rtl/exc_flush_mask.sv
module exc_flush_mask
  import exc_flush_pkg::*;
(
  input  logic              hit,
  input  logic [SELW-1:0]   sel,
  output logic [NSTAGE-1:0] mask
);
  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    assign mask[s] = hit && ({1'b0, sel} >= (SELW+1)'(s));
  end
endmodule

// File: rtl/exc_record.sv
module exc_record
  import exc_flush_pkg::*;
#(
  parameter int PCW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [NSTAGE-1:0] mask,
  input  exc_cause_t        cause_nx,
  input  logic [PCW-1:0]    pc_nx,
  input  logic              ds_nx,
  input  logic [PCW-1:0]    bpc_nx,
  input  logic [PCW-1:0]    tgt_nx,
  output logic [NSTAGE-1:0] flush,
  output logic              trap_fetch,
  output logic [PCW-1:0]    epc,
  output logic [2:0]        cause,
  output logic              epc_in_dslot,
  output logic [PCW-1:0]    epc_branch_pc,
  output logic [PCW-1:0]    epc_branch_tgt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flush          <= '0;
      trap_fetch     <= 1'b0;
      epc            <= '0;
      cause          <= '0;
      epc_in_dslot   <= 1'b0;
      epc_branch_pc  <= '0;
      epc_branch_tgt <= '0;
    end else begin
      flush      <= mask;
      trap_fetch <= hit;
      if (hit) begin
        epc            <= pc_nx;
        cause          <= cause_nx;
        epc_in_dslot   <= ds_nx;
        epc_branch_pc  <= ds_nx ? bpc_nx : '0;
        epc_branch_tgt <= ds_nx ? tgt_nx : '0;
      end
    end
  end
endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
  import exc_flush_pkg::*;
#(
  parameter int PCW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            if_exc,
  input  logic                  id_exc,
  input  logic                  ex_exc,
  input  logic [2:0]            mem_exc,
  input  logic [NSTAGE*PCW-1:0] stage_pc,
  input  logic [NFAULT-1:0]     stage_dslot,
  input  logic [NFAULT*PCW-1:0] stage_tgt,
  output logic [NSTAGE-1:0]     flush,
  output logic                  trap_fetch,
  output logic [PCW-1:0]        epc,
  output logic [2:0]            cause,
  output logic                  epc_in_dslot,
  output logic [PCW-1:0]        epc_branch_pc,
  output logic [PCW-1:0]        epc_branch_tgt
);
  logic [PCW-1:0]    pc_a  [NSTAGE];
  logic [PCW-1:0]    tgt_a [NFAULT];
  logic [NFAULT-1:0] any_fault;
  logic              hit;
  logic [SELW-1:0]   sel;
  exc_cause_t        cause_nx;
  logic [NSTAGE-1:0] mask;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_pc
    assign pc_a[s] = stage_pc[s*PCW +: PCW];
  end
  for (genvar s = 0; s < NFAULT; s++) begin : g_tgt
    assign tgt_a[s] = stage_tgt[s*PCW +: PCW];
  end

  assign any_fault = {|mem_exc, ex_exc, id_exc, |if_exc};

  exc_select u_sel (
    .if_exc   (if_exc),
    .mem_exc  (mem_exc),
    .any_fault(any_fault),
    .hit      (hit),
    .sel      (sel),
    .cause_nx (cause_nx)
  );

  exc_flush_mask u_mask (
    .hit (hit),
    .sel (sel),
    .mask(mask)
  );

  exc_record #(.PCW(PCW)) u_rec (
    .clk           (clk),
    .rst           (rst),
    .hit           (hit),
    .mask          (mask),
    .cause_nx      (cause_nx),
    .pc_nx         (pc_a[sel]),
    .ds_nx         (stage_dslot[sel]),
    .bpc_nx        (pc_a[{1'b0, sel} + 3'd1]),
    .tgt_nx        (tgt_a[sel]),
    .flush         (flush),
    .trap_fetch    (trap_fetch),
    .epc           (epc),
    .cause         (cause),
    .epc_in_dslot  (epc_in_dslot),
    .epc_branch_pc (epc_branch_pc),
    .epc_branch_tgt(epc_branch_tgt)
  );
endmodule

// File: rtl/exc_flush_chk.sv
module exc_flush_chk #(
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [2:0]     if_exc,
  input logic           id_exc,
  input logic           ex_exc,
  input logic [2:0]     mem_exc,
  input logic [4:0]     flush,
  input logic           trap_fetch,
  input logic [PCW-1:0] epc,
  input logic [2:0]     cause
);
  p_trap_flush_r2: assert property (@(posedge clk) disable iff (rst)
    trap_fetch |-> flush[0]);
  p_idle_noflush_r8: assert property (@(posedge clk) disable iff (rst)
    !trap_fetch |-> (flush == 5'd0));
  p_prefix_r3: assert property (@(posedge clk) disable iff (rst)
    (flush & 5'(flush + 5'd1)) == 5'd0);
  p_wb_kept_r9: assert property (@(posedge clk) disable iff (rst)
    !flush[4]);
  p_mem_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (|mem_exc) |=> (trap_fetch && flush[3] && cause >= 3'd5));
  p_arith_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_exc && !(|mem_exc)) |=> (cause == 3'd4 && flush == 5'b00111));
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !(|if_exc || id_exc || ex_exc || |mem_exc) |=>
      (!trap_fetch && $stable(epc) && $stable(cause)));
endmodule

bind exc_flush_ctrl exc_flush_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .if_exc(if_exc), .id_exc(id_exc),
  .ex_exc(ex_exc), .mem_exc(mem_exc), .flush(flush),
  .trap_fetch(trap_fetch), .epc(epc), .cause(cause)
);

// File: tb/exc_flush_ctrl_tb.sv
module exc_flush_ctrl_tb;
  localparam int PCW = 16;

  logic           clk = 1'b0;
  logic           rst;
  logic [2:0]     if_exc, mem_exc;
  logic           id_exc, ex_exc;
  logic [5*PCW-1:0] stage_pc;
  logic [3:0]     stage_dslot;
  logic [4*PCW-1:0] stage_tgt;
  logic [4:0]     flush;
  logic           trap_fetch;
  logic [PCW-1:0] epc, epc_branch_pc, epc_branch_tgt;
  logic [2:0]     cause;
  logic           epc_in_dslot;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_flush_ctrl #(.PCW(PCW)) u_dut (
    .clk(clk), .rst(rst), .if_exc(if_exc), .id_exc(id_exc), .ex_exc(ex_exc),
    .mem_exc(mem_exc), .stage_pc(stage_pc), .stage_dslot(stage_dslot),
    .stage_tgt(stage_tgt), .flush(flush), .trap_fetch(trap_fetch), .epc(epc),
    .cause(cause), .epc_in_dslot(epc_in_dslot), .epc_branch_pc(epc_branch_pc),
    .epc_branch_tgt(epc_branch_tgt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] lowb(input logic [2:0] v);
    return v[0] ? 3'd0 : (v[1] ? 3'd1 : 3'd2);
  endfunction

  initial begin
    logic [PCW-1:0] e_epc, e_bpc, e_tgt;
    logic [2:0] e_cause;
    logic e_ds;
    e_epc = '0; e_bpc = '0; e_tgt = '0; e_cause = '0; e_ds = 1'b0;
    rst = 1'b1; if_exc = '0; id_exc = 0; ex_exc = 0; mem_exc = '0;
    stage_pc = '0; stage_dslot = '0; stage_tgt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 flush", 32'(flush), 0);
    chk("R1 trap", 32'(trap_fetch), 0);
    chk("R1 epc", 32'(epc), 0);
    chk("R1 cause", 32'(cause), 0);
    chk("R1 dslot", {epc_in_dslot, epc_branch_pc, epc_branch_tgt}, 0);

    for (int v = 0; v < 256; v++) begin
      int k;
      logic [4:0] e_fl;
      // drive a fault combination
      {mem_exc, ex_exc, id_exc, if_exc} = 8'(v);
      stage_dslot = 4'(v * 7 + 3);
      for (int s = 0; s < 5; s++) stage_pc[s*PCW +: PCW] = 16'((v << 4) + s * 4 + 16'h1000);
      for (int s = 0; s < 4; s++) stage_tgt[s*PCW +: PCW] = 16'((v << 5) ^ (s * 16'h0111) ^ 16'h8000);
      k = (|mem_exc) ? 3 : ex_exc ? 2 : id_exc ? 1 : (|if_exc) ? 0 : -1;
      if (k >= 0) begin
        e_epc = stage_pc[k*PCW +: PCW];
        e_cause = (k == 3) ? 3'(5 + lowb(mem_exc)) : (k == 2) ? 3'd4 :
                  (k == 1) ? 3'd3 : lowb(if_exc);
        e_ds = stage_dslot[k];
        e_bpc = e_ds ? stage_pc[(k+1)*PCW +: PCW] : '0;
        e_tgt = e_ds ? stage_tgt[k*PCW +: PCW] : '0;
        e_fl = 5'((1 << (k + 1)) - 1);
      end else e_fl = '0;
      @(negedge clk);
      chk("R2 trap", 32'(trap_fetch), 32'(k >= 0));
      chk("R3 R4 R9 flush", 32'(flush), 32'(e_fl));
      chk("R5 cause", 32'(cause), 32'(e_cause));
      chk("R6 epc", 32'(epc), 32'(e_epc));
      chk("R7 dslot", 32'(epc_in_dslot), 32'(e_ds));
      chk("R7 bpc", 32'(epc_branch_pc), 32'(e_bpc));
      chk("R7 tgt", 32'(epc_branch_tgt), 32'(e_tgt));
      // idle cycle with changed PCs: state must hold
      {mem_exc, ex_exc, id_exc, if_exc} = 8'd0;
      stage_pc = ~stage_pc; stage_dslot = ~stage_dslot; stage_tgt = ~stage_tgt;
      @(negedge clk);
      chk("R8 trap", 32'(trap_fetch), 0);
      chk("R8 flush", 32'(flush), 0);
      chk("R8 epc", 32'(epc), 32'(e_epc));
      chk("R8 cause", 32'(cause), 32'(e_cause));
      chk("R8 bpc", 32'(epc_branch_pc), 32'(e_bpc));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule